// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital side of an integrating dual-slope analog-to-digital converter. Between conversions it holds the analog front end in autozero: the input selector is on ground and the autozero switch is closed. A start request launches a conversion. The selector moves to the unknown signal for a fixed window of 2^n clocks, which is one full wrap of an n-bit counter. It then moves to the reference, and the counter runs again from zero until the comparator reports that the integrator has crossed back over its threshold. The count at that moment is the result, and it is proportional to the input divided by the reference.

The comparator output is asynchronous to the clock. It passes through a two-flop synchronizer, and one further register detects a change of level in either direction. If the reference phase runs for 2^n clocks without a crossing, the result saturates and an over-range flag is raised. End-of-conversion and the result stay valid until the next accepted start. The selector returns to ground with autozero closed in the same cycle that end-of-conversion rises. Choosing the integration window as a whole number of mains periods lets the integration cancel mains hum. A conversion lasts at most about twice that window.

Top module: `dslope_adc_ctl`

## Requirements
- R1: During and right after reset, sel_o is 2'b00 (ground), az_o is 1, and eoc_o, ovr_o and result_o are all zero.
- R2: While no start is accepted, sel_o stays 2'b00 with az_o = 1. az_o is 1 exactly when sel_o is 2'b00.
- R3: A start_i high at a clock edge while idle makes sel_o 2'b01 (signal) and az_o 0 after that edge, and clears eoc_o and ovr_o.
- R4: The signal phase lasts exactly 2^n clocks. After that, sel_o becomes 2'b10 (reference). sel_o never takes the value 2'b11 and never goes from reference back to signal.
- R5: A comparator change that appears after reference clock j is recognized two clocks later, because of the synchronizer and edge stage. result_o is then j+2, and eoc_o rises after the edge that follows 2^n+j+3 clocks counted from the start edge.
- R6: eoc_o, ovr_o and result_o hold their values until the next accepted start. eoc_o falls on that start.
- R7: If no change is recognized within 2^n reference clocks, result_o becomes all ones, ovr_o becomes 1, and eoc_o rises 2^(n+1) clocks after the start edge.
- R8: A start_i pulse during the signal or the reference phase has no effect on the timing or on the result.
- R9: Whenever eoc_o is 1, sel_o is 2'b00 and az_o is 1.
- R10: A rising comparator change and a falling one are recognized in the same way.
- R11: A change recognized on the final reference clock, when the count is all ones, gives result_o all ones with ovr_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled only while idle |
| cmp_i | input | 1 | Asynchronous comparator output |
| sel_o | output | 2 | Input selector: 00 ground, 01 signal, 10 reference |
| az_o | output | 1 | Autozero switch closed when 1 |
| eoc_o | output | 1 | End of conversion, held until next start |
| ovr_o | output | 1 | Over-range flag |
| result_o | output | CNT_W | Conversion result |

## Verification
Every result is due a fixed number of edges after the start edge. The selector reaches signal one edge later and reference 2^n edges later. End-of-conversion comes after 2^n+k+3 edges for an integrator that returns after k reference clocks, or after 2^(n+1) edges on over-range. The bench counts edges from the start edge and samples on the falling edge. It requires eoc_o to rise at exactly the predicted count, not merely at some point. Its integrator model updates on the same edges that the selector drives, so the comparator lag that the bench assumes matches the lag stated in R5.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [1:0] {
        SEL_GND = 2'b00,
        SEL_SIG = 2'b01,
        SEL_REF = 2'b10
    } sel_e;

    typedef enum logic [1:0] {
        PH_AZERO = 2'b00,
        PH_INTEG = 2'b01,
        PH_DEINT = 2'b10
    } phase_e;

endpackage

// File: rtl/dslope_edge_sync.sv
module dslope_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic change_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;
    logic [DEPTH-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    // Synchronized level compared with its previous sample
    assign change_o = chain_q[DEPTH-1] ^ chain_q[DEPTH-2];

endmodule

// File: rtl/dslope_ctl.sv
module dslope_ctl
    import dslope_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             change_i,
    output sel_e             sel_o,
    output logic             az_o,
    output logic             eoc_o,
    output logic             ovr_o,
    output logic [CNT_W-1:0] result_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] res;
        logic             eoc;
        logic             ovr;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_AZERO: begin
                if (start_i) begin
                    ctl_d.phase = PH_INTEG;
                    ctl_d.cnt   = '0;
                    ctl_d.eoc   = 1'b0;
                    ctl_d.ovr   = 1'b0;
                end
            end
            PH_INTEG: begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == CNT_TOP) ctl_d.phase = PH_DEINT;
            end
            PH_DEINT: begin
                if (change_i) begin
                    ctl_d.res   = ctl_q.cnt;
                    ctl_d.eoc   = 1'b1;
                    ctl_d.phase = PH_AZERO;
                end else if (ctl_q.cnt == CNT_TOP) begin
                    ctl_d.res   = CNT_TOP;
                    ctl_d.ovr   = 1'b1;
                    ctl_d.eoc   = 1'b1;
                    ctl_d.phase = PH_AZERO;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.phase = PH_AZERO;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.phase <= PH_AZERO;
            ctl_q.cnt   <= '0;
            ctl_q.res   <= '0;
            ctl_q.eoc   <= 1'b0;
            ctl_q.ovr   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        unique case (ctl_q.phase)
            PH_INTEG: sel_o = SEL_SIG;
            PH_DEINT: sel_o = SEL_REF;
            default:  sel_o = SEL_GND;
        endcase
    end

    assign az_o     = (ctl_q.phase == PH_AZERO);
    assign eoc_o    = ctl_q.eoc;
    assign ovr_o    = ctl_q.ovr;
    assign result_o = ctl_q.res;

endmodule

// File: rtl/dslope_adc_ctl.sv
module dslope_adc_ctl
    import dslope_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [1:0]       sel_o,
    output logic             az_o,
    output logic             eoc_o,
    output logic             ovr_o,
    output logic [CNT_W-1:0] result_o
);
    logic cmp_change;
    sel_e sel_int;

    dslope_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .async_i  (cmp_i),
        .change_o (cmp_change)
    );

    dslope_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .change_i (cmp_change),
        .sel_o    (sel_int),
        .az_o     (az_o),
        .eoc_o    (eoc_o),
        .ovr_o    (ovr_o),
        .result_o (result_o)
    );

    assign sel_o = sel_int;

endmodule

// File: rtl/dslope_adc_ctl_chk.sv
module dslope_adc_ctl_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [1:0]       sel_o,
    input logic             az_o,
    input logic             eoc_o,
    input logic             ovr_o,
    input logic [CNT_W-1:0] result_o
);
    a_r2_az_with_ground: assert property (@(posedge clk_i) disable iff (!rst_ni)
        az_o == (sel_o == 2'b00));

    a_r3_start_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o == 2'b00 && start_i) |=> (sel_o == 2'b01 && !eoc_o && !ovr_o));

    a_r4_legal_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_o != 2'b11);

    a_r4_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o == 2'b10) |=> (sel_o != 2'b01));

    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoc_o && !start_i) |=> (eoc_o && $stable(result_o) && $stable(ovr_o)));

    a_r7_ovr_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_o |-> (eoc_o && result_o == {CNT_W{1'b1}}));

    a_r8_no_early_ground: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o == 2'b01) |=> (sel_o != 2'b00));

    a_r9_eoc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoc_o |-> (sel_o == 2'b00 && az_o));

endmodule

bind dslope_adc_ctl dslope_adc_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .sel_o    (sel_o),
    .az_o     (az_o),
    .eoc_o    (eoc_o),
    .ovr_o    (ovr_o),
    .result_o (result_o)
);

// File: tb/dslope_adc_ctl_test.sv
`timescale 1ns/1ps
module dslope_adc_ctl_test;
    localparam int N    = 8;
    localparam int FULL = 1 << N;
    localparam int TOP  = FULL - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp;
    logic [1:0]   sel;
    logic         az, eoc, ovr;
    logic [N-1:0] result;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  inv   = 1'b0;
    int  vin   = 0;
    int  acc   = 0;

    always #4 clk = ~clk;

    dslope_adc_ctl #(.CNT_W(N)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
        .sel_o(sel), .az_o(az), .eoc_o(eoc), .ovr_o(ovr), .result_o(result)
    );

    // Behavioural integrator: signal adds vin per clock, reference removes FULL
    always @(posedge clk) begin
        case (sel)
            2'b01:   acc <= acc + vin;
            2'b10:   acc <= acc - FULL;
            default: acc <= 0;
        endcase
    end
    assign cmp = inv ^ (acc > 0);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_ovr(input int k);
        return !(k >= 1 && k <= FULL - 3);
    endfunction

    function automatic int exp_res(input int k);
        return exp_ovr(k) ? TOP : k + 2;
    endfunction

    function automatic int exp_lat(input int k);
        return exp_ovr(k) ? 2 * FULL : FULL + k + 3;
    endfunction

    task automatic convert(input int k, input bit pol, input bit glitch);
        int t;
        string rtag;
        rtag = pol ? "R10" : "R5";
        if (k == FULL - 3) rtag = "R11";
        vin = k;
        inv = pol;
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 1;
        chk("R3 sel", sel, 1);
        chk("R3 az", az, 0);
        chk("R6 eoc falls", eoc, 0);
        while (!eoc && t < 4 * FULL) begin
            start = glitch && (t == 5 || t == FULL + 2);
            @(negedge clk);
            t++;
            if (t == FULL)     chk("R4 still signal", sel, 1);
            if (t == FULL + 1) chk("R4 reference", sel, 2);
        end
        start = 1'b0;
        chk(glitch ? "R8 timing" : "R5 timing", t, exp_lat(k) + 1);
        chk(rtag, result, exp_res(k));
        chk(exp_ovr(k) ? "R7 ovr" : "R5 ovr", ovr, exp_ovr(k));
        chk("R9 sel", sel, 0);
        chk("R9 az", az, 1);
        repeat (3) @(negedge clk);
        chk("R6 eoc hold", eoc, 1);
        chk("R6 result hold", result, exp_res(k));
    endtask

    initial begin
        void'($urandom(32'd20240));
        #1;
        chk("R1 sel", sel, 0);
        chk("R1 az", az, 1);
        chk("R1 eoc", eoc, 0);
        chk("R1 ovr", ovr, 0);
        chk("R1 result", result, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 sel", sel, 0);
        chk("R2 az", az, 1);
        chk("R2 eoc", eoc, 0);
        convert(1, 1'b0, 1'b0);
        convert(FULL / 2, 1'b1, 1'b0);
        convert(FULL - 3, 1'b0, 1'b0);
        convert(FULL - 2, 1'b0, 1'b0);
        convert(0, 1'b1, 1'b0);
        convert(FULL + 9, 1'b0, 1'b0);
        convert(40, 1'b0, 1'b1);
        convert(FULL - 3, 1'b1, 1'b1);
        for (int i = 0; i < 20; i++) begin
            convert($urandom_range(FULL + 4, 0), 1'($urandom_range(1, 0)),
                    1'($urandom_range(1, 0)));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule